// File: doc/BRIEF.md
# Per-Bit Write Data Eye Trainer

This block finds a safe write-data delay for every DQ line of a memory channel. For one lane at a time it sweeps the lane's delay tap from the lowest value to the highest. At each tap it writes a short burst to a few fixed locations, reads those locations back through a valid/ready request port, and waits until every read beat has returned. It then judges only the lane under test. It records the taps that pass, keeps the first unbroken run of them, and sets that lane's delay to the centre of the run.

The stimulus alternates on every beat, so each lane toggles on every transfer. When the sweep over all lanes is complete, the block presents the following results: the left and right edge of each lane's window, the programmed delays, a per-lane fail flag for a lane with no passing tap, and a per-lane marginal flag for a window narrower than a programmable minimum. An error output is raised if any lane failed. The delay field of each lane drives the external delay line directly, and the lane under test sees the sweep tap while its sweep is in progress.

Top module: `wtrain_top`

## Requirements
- R1: While reset is high, and in the cycle after it is released, busy, done, err and req_valid are 0, and every delay, edge and flag output is 0.
- R2: Each step writes BURST beats to addresses 0..BURST-1 in rising order, then reads the same addresses in the same order. Bit b of beat k is 1 exactly when (k+b) is odd, so each lane alternates on every beat.
- R3: While req_valid is high and req_ready is low, req_valid, req_addr, req_write and req_wdata hold their values into the next cycle.
- R4: Lanes are trained in the order 0..NUM_DQ-1, and taps are stepped in the order 0..2^TAP_W-1. During a lane's sweep, its dq_delay field (bits [b*TAP_W +: TAP_W]) carries the current tap.
- R5: A tap passes only when all BURST returned beats match the pattern on the lane under test. The tap is judged only after the last beat has come back, including a mismatch on the final beat.
- R6: edge_left and edge_right (same field layout as dq_delay) are the first and last taps of the lowest-numbered contiguous run of passing taps. Later runs are ignored.
- R7: A lane that has a passing tap gets dq_delay = floor((left+right)/2).
- R8: A lane with no passing tap has bit_fail set, with delay and edges 0, and err is high after training.
- R9: bit_marginal is set for a lane that has a window whose width (right-left+1) is smaller than min_win. It is never set for a failed lane.
- R10: busy is high from the cycle after start until training ends. Then done is high, busy is low and no request is issued. A new start from the done state clears the results and trains again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a training run (accepted when idle or done) |
| min_win | input | TAP_W+1 | Narrowest window width not flagged as marginal |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_write | output | 1 | 1 for write, 0 for read |
| req_addr | output | $clog2(BURST) | Beat address |
| req_wdata | output | NUM_DQ | Write data |
| rd_valid | input | 1 | Read data beat valid (in request order) |
| rd_data | input | NUM_DQ | Read data beat |
| busy | output | 1 | Training in progress |
| done | output | 1 | Training finished |
| err | output | 1 | At least one lane has no passing tap |
| dq_delay | output | NUM_DQ*TAP_W | Per-lane write delay tap |
| edge_left | output | NUM_DQ*TAP_W | Per-lane first passing tap |
| edge_right | output | NUM_DQ*TAP_W | Per-lane last passing tap |
| bit_fail | output | NUM_DQ | Lane has no passing tap |
| bit_marginal | output | NUM_DQ | Lane window narrower than min_win |

## Verification
Read beats for a step can return while the controller is still issuing that step's read requests, so the comparator is counting and judging returns in the same cycle that a new request is held or accepted. The bench provokes this with a short fixed read latency combined with a request port that refuses one cycle in three. Corruption is injected only on the last beat of each step, which exposes a verdict taken before all data is back. Edges, centres and flags are then compared against values the bench derives from per-lane pass masks, including a lane with two separate runs and a lane with none.

// File: rtl/wtrain_pkg.sv
package wtrain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_RD,
        ST_WAIT,
        ST_JUDGE,
        ST_NEXT,
        ST_DONE
    } sweep_st_e;

    // Flags of the window being tracked for the current lane
    typedef struct packed {
        logic found;   // a passing tap has been seen
        logic closed;  // the first run has ended
    } run_flags_t;

    // Training stimulus: lane value for a beat, toggling every beat
    function automatic logic pat_bit(input int unsigned beat, input int unsigned lane);
        return ((beat + lane) % 2) == 1;
    endfunction

endpackage

// File: rtl/wtrain_ctrl.sv
module wtrain_ctrl
    import wtrain_pkg::*;
#(
    parameter int NUM_DQ = 4,
    parameter int TAP_W  = 4,
    parameter int BURST  = 4,
    localparam int AW    = $clog2(BURST),
    localparam int BIT_W = $clog2(NUM_DQ)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              req_ready,
    input  logic              all_back,
    output logic              req_valid,
    output logic              req_write,
    output logic [AW-1:0]     req_addr,
    output logic [NUM_DQ-1:0] req_wdata,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [TAP_W-1:0]  tap,
    output logic              busy,
    output logic              done,
    output logic              judge,
    output logic              bit_end,
    output logic              cmp_clr,
    output logic              trk_clr,
    output logic              run_start
);

    localparam logic [AW-1:0]    LAST_BEAT = AW'(BURST - 1);
    localparam logic [TAP_W-1:0] LAST_TAP  = {TAP_W{1'b1}};
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(NUM_DQ - 1);

    sweep_st_e         st;
    logic [AW-1:0]     issue;
    logic [NUM_DQ-1:0] pat_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            bit_idx <= '0;
            tap     <= '0;
            issue   <= '0;
        end else begin
            case (st)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        st      <= ST_WR;
                        bit_idx <= '0;
                        tap     <= '0;
                        issue   <= '0;
                    end
                end
                ST_WR: begin
                    if (req_ready) begin
                        if (issue == LAST_BEAT) begin
                            issue <= '0;
                            st    <= ST_RD;
                        end else begin
                            issue <= issue + 1'b1;
                        end
                    end
                end
                ST_RD: begin
                    if (req_ready) begin
                        if (issue == LAST_BEAT) begin
                            issue <= '0;
                            st    <= ST_WAIT;
                        end else begin
                            issue <= issue + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (all_back) st <= ST_JUDGE;
                end
                ST_JUDGE: begin
                    if (tap == LAST_TAP) begin
                        st <= ST_NEXT;
                    end else begin
                        tap <= tap + 1'b1;
                        st  <= ST_WR;
                    end
                end
                ST_NEXT: begin
                    tap <= '0;
                    if (bit_idx == LAST_BIT) begin
                        st <= ST_DONE;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        st      <= ST_WR;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    for (genvar b = 0; b < NUM_DQ; b++) begin : g_pat
        assign pat_word[b] = pat_bit(32'(issue), 32'(b));
    end

    always_comb begin
        req_valid = (st == ST_WR) || (st == ST_RD);
        req_write = (st == ST_WR);
        req_addr  = issue;
        req_wdata = (st == ST_WR) ? pat_word : '0;
        busy      = (st != ST_IDLE) && (st != ST_DONE);
        done      = (st == ST_DONE);
        judge     = (st == ST_JUDGE);
        bit_end   = (st == ST_NEXT);
        cmp_clr   = !((st == ST_WR) || (st == ST_RD) || (st == ST_WAIT));
        trk_clr   = (st == ST_IDLE) || (st == ST_NEXT) || (st == ST_DONE);
        run_start = start && ((st == ST_IDLE) || (st == ST_DONE));
    end

endmodule

// File: rtl/wtrain_cmp.sv
module wtrain_cmp
    import wtrain_pkg::*;
#(
    parameter int NUM_DQ = 4,
    parameter int BURST  = 4,
    localparam int BIT_W = $clog2(NUM_DQ),
    localparam int CW    = $clog2(BURST + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              rd_valid,
    input  logic [NUM_DQ-1:0] rd_data,
    input  logic [BIT_W-1:0]  bit_idx,
    output logic              all_back,
    output logic              step_pass
);

    localparam logic [CW-1:0] FULL = CW'(BURST);

    logic [CW-1:0] ret_cnt;
    logic          mis;
    logic          expect_bit;

    assign expect_bit = pat_bit(32'(ret_cnt), 32'(bit_idx));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ret_cnt <= '0;
            mis     <= 1'b0;
        end else if (rd_valid && (ret_cnt != FULL)) begin
            ret_cnt <= ret_cnt + 1'b1;
            if (rd_data[bit_idx] != expect_bit) mis <= 1'b1;
        end
    end

    assign all_back  = (ret_cnt == FULL);
    assign step_pass = !mis;

endmodule

// File: rtl/wtrain_edge.sv
module wtrain_edge
    import wtrain_pkg::*;
#(
    parameter int TAP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             judge,
    input  logic             pass,
    input  logic [TAP_W-1:0] tap,
    output logic             found,
    output logic [TAP_W-1:0] left_tap,
    output logic [TAP_W-1:0] right_tap
);

    run_flags_t fl;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fl        <= '0;
            left_tap  <= '0;
            right_tap <= '0;
        end else if (judge) begin
            if (pass) begin
                if (!fl.found) begin
                    fl.found  <= 1'b1;
                    left_tap  <= tap;
                    right_tap <= tap;
                end else if (!fl.closed) begin
                    right_tap <= tap;
                end
            end else if (fl.found) begin
                fl.closed <= 1'b1;
            end
        end
    end

    assign found = fl.found;

endmodule

// File: rtl/wtrain_top.sv
module wtrain_top
    import wtrain_pkg::*;
#(
    parameter int NUM_DQ = 4,
    parameter int TAP_W  = 4,
    parameter int BURST  = 4,
    localparam int AW    = $clog2(BURST),
    localparam int BIT_W = $clog2(NUM_DQ)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [TAP_W:0]          min_win,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic                    req_write,
    output logic [AW-1:0]           req_addr,
    output logic [NUM_DQ-1:0]       req_wdata,
    input  logic                    rd_valid,
    input  logic [NUM_DQ-1:0]       rd_data,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic [NUM_DQ*TAP_W-1:0] dq_delay,
    output logic [NUM_DQ*TAP_W-1:0] edge_left,
    output logic [NUM_DQ*TAP_W-1:0] edge_right,
    output logic [NUM_DQ-1:0]       bit_fail,
    output logic [NUM_DQ-1:0]       bit_marginal
);

    logic [BIT_W-1:0] bit_idx;
    logic [TAP_W-1:0] tap;
    logic             all_back, step_pass, judge, bit_end;
    logic             cmp_clr, trk_clr, run_start;
    logic             found;
    logic [TAP_W-1:0] win_l, win_r;

    wtrain_ctrl #(.NUM_DQ(NUM_DQ), .TAP_W(TAP_W), .BURST(BURST)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .req_ready(req_ready),
        .all_back(all_back), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .bit_idx(bit_idx),
        .tap(tap), .busy(busy), .done(done), .judge(judge),
        .bit_end(bit_end), .cmp_clr(cmp_clr), .trk_clr(trk_clr),
        .run_start(run_start)
    );

    wtrain_cmp #(.NUM_DQ(NUM_DQ), .BURST(BURST)) u_cmp (
        .clk(clk), .rst(rst), .clr(cmp_clr), .rd_valid(rd_valid),
        .rd_data(rd_data), .bit_idx(bit_idx), .all_back(all_back),
        .step_pass(step_pass)
    );

    wtrain_edge #(.TAP_W(TAP_W)) u_edge (
        .clk(clk), .rst(rst), .clr(trk_clr), .judge(judge),
        .pass(step_pass), .tap(tap), .found(found),
        .left_tap(win_l), .right_tap(win_r)
    );

    // Window centre and width for the lane just finished
    logic [TAP_W:0]   win_sum, win_width;
    logic [TAP_W-1:0] win_mid;
    logic             win_narrow;

    always_comb begin
        win_sum    = {1'b0, win_l} + {1'b0, win_r};
        win_mid    = win_sum[TAP_W:1];
        win_width  = {1'b0, win_r} - {1'b0, win_l} + 1'b1;
        win_narrow = found && (win_width < min_win);
    end

    logic [TAP_W-1:0] dly_q   [NUM_DQ];
    logic [TAP_W-1:0] left_q  [NUM_DQ];
    logic [TAP_W-1:0] right_q [NUM_DQ];
    logic             fail_q  [NUM_DQ];
    logic             marg_q  [NUM_DQ];

    for (genvar b = 0; b < NUM_DQ; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || run_start) begin
                dly_q[b]   <= '0;
                left_q[b]  <= '0;
                right_q[b] <= '0;
                fail_q[b]  <= 1'b0;
                marg_q[b]  <= 1'b0;
            end else if (bit_end && (bit_idx == BIT_W'(b))) begin
                dly_q[b]   <= found ? win_mid : '0;
                left_q[b]  <= found ? win_l : '0;
                right_q[b] <= found ? win_r : '0;
                fail_q[b]  <= !found;
                marg_q[b]  <= win_narrow;
            end
        end

        assign dq_delay[b*TAP_W +: TAP_W]   = (busy && (bit_idx == BIT_W'(b))) ? tap : dly_q[b];
        assign edge_left[b*TAP_W +: TAP_W]  = left_q[b];
        assign edge_right[b*TAP_W +: TAP_W] = right_q[b];
        assign bit_fail[b]                  = fail_q[b];
        assign bit_marginal[b]              = marg_q[b];
    end

    assign err = |bit_fail;

endmodule

// File: rtl/wtrain_chk.sv
module wtrain_chk #(
    parameter int NUM_DQ = 4,
    parameter int TAP_W  = 4,
    parameter int AW     = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic                    req_write,
    input logic [AW-1:0]           req_addr,
    input logic [NUM_DQ-1:0]       req_wdata,
    input logic                    busy,
    input logic                    done,
    input logic [NUM_DQ*TAP_W-1:0] dq_delay,
    input logic [NUM_DQ*TAP_W-1:0] edge_left,
    input logic [NUM_DQ*TAP_W-1:0] edge_right,
    input logic [NUM_DQ-1:0]       bit_fail,
    input logic [NUM_DQ-1:0]       bit_marginal
);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                    && $stable(req_write) && $stable(req_wdata));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !req_valid);

    // R10
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    // R9
    marg_not_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_marginal & bit_fail) == '0);

    for (genvar b = 0; b < NUM_DQ; b++) begin : g_lane_chk
        // R7
        centre_inside_chk: assert property (@(posedge clk) disable iff (rst)
            done && !bit_fail[b] |->
                (edge_left[b*TAP_W +: TAP_W] <= dq_delay[b*TAP_W +: TAP_W]) &&
                (dq_delay[b*TAP_W +: TAP_W] <= edge_right[b*TAP_W +: TAP_W]));

        // R8
        fail_zero_chk: assert property (@(posedge clk) disable iff (rst)
            done && bit_fail[b] |->
                (edge_left[b*TAP_W +: TAP_W] == '0) &&
                (edge_right[b*TAP_W +: TAP_W] == '0) &&
                (dq_delay[b*TAP_W +: TAP_W] == '0));
    end

endmodule

bind wtrain_top wtrain_chk #(.NUM_DQ(NUM_DQ), .TAP_W(TAP_W), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .dq_delay(dq_delay), .edge_left(edge_left),
    .edge_right(edge_right), .bit_fail(bit_fail), .bit_marginal(bit_marginal)
);

// File: tb/sim_wtrain_top.sv
module sim_wtrain_top;
    localparam int N    = 4;
    localparam int TW   = 4;
    localparam int BL   = 4;
    localparam int TAPS = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst, start, req_valid, req_ready, req_write;
    logic [TW:0]     min_win;
    logic [1:0]      req_addr;
    logic [N-1:0]    req_wdata, rd_data;
    logic            rd_valid, busy, done, err;
    logic [N*TW-1:0] dq_delay, edge_left, edge_right;
    logic [N-1:0]    bit_fail, bit_marginal;

    wtrain_top #(.NUM_DQ(N), .TAP_W(TW), .BURST(BL)) u0 (
        .clk(clk), .rst(rst), .start(start), .min_win(min_win),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .busy(busy), .done(done), .err(err),
        .dq_delay(dq_delay), .edge_left(edge_left), .edge_right(edge_right),
        .bit_fail(bit_fail), .bit_marginal(bit_marginal)
    );

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int wcnt = 0;
    int rcnt = 0;
    logic [15:0]  msk [N];
    logic [N-1:0] mem [BL];
    logic         pv  [3];
    logic [N-1:0] pd  [3];
    logic         hold_pend = 1'b0;
    logic [1:0]   hold_addr;
    logic         hold_wr;
    logic [N-1:0] hold_wd;
    int el [N], er [N], ed [N];
    bit ef [N], em [N];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Memory model: fixed read latency, optional stalls, corruption of the
    // last beat for any lane whose current tap lies outside its pass mask
    initial begin
        req_ready = 1'b0;
        rd_valid  = 1'b0;
        rd_data   = '0;
        for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pd[i] = '0; end
        for (int i = 0; i < BL; i++) mem[i] = '0;
        forever begin
            @(negedge clk);
            cyc++;
            rd_valid = pv[2]; rd_data = pd[2];
            pv[2] = pv[1]; pd[2] = pd[1];
            pv[1] = pv[0]; pd[1] = pd[0];
            pv[0] = 1'b0;
            req_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
            if (hold_pend) begin
                chk(req_valid && req_addr == hold_addr && req_write == hold_wr
                    && req_wdata == hold_wd, "R3 hold", int'(req_addr), int'(hold_addr));
                hold_pend = 1'b0;
            end
            if (req_valid && !req_ready) begin
                hold_pend = 1'b1;
                hold_addr = req_addr;
                hold_wr   = req_write;
                hold_wd   = req_wdata;
            end
            if (req_valid && req_ready) begin
                if (req_write) begin
                    int k, stp, eb, et;
                    logic [N-1:0] ew, d;
                    k   = wcnt % BL;
                    stp = wcnt / BL;
                    eb  = stp / TAPS;
                    et  = stp % TAPS;
                    for (int b = 0; b < N; b++) ew[b] = ((k + b) % 2) == 1;
                    chk(int'(req_addr) == k, "R2 write addr", int'(req_addr), k);
                    chk(req_wdata == ew, "R2 write data", int'(req_wdata), int'(ew));
                    chk(int'(dq_delay[eb*TW +: TW]) == et, "R4 sweep tap",
                        int'(dq_delay[eb*TW +: TW]), et);
                    d = req_wdata;
                    if (int'(req_addr) == BL - 1)
                        for (int b = 0; b < N; b++)
                            if (!msk[b][dq_delay[b*TW +: TW]]) d[b] = ~d[b];
                    mem[req_addr] = d;
                    wcnt++;
                end else begin
                    chk(int'(req_addr) == rcnt % BL, "R2 read addr", int'(req_addr), rcnt % BL);
                    pv[0] = 1'b1;
                    pd[0] = mem[req_addr];
                    rcnt++;
                end
            end
        end
    end

    task automatic expect_from_masks(input int minw);
        for (int b = 0; b < N; b++) begin
            bit f, c;
            int l, r;
            f = 0; c = 0; l = 0; r = 0;
            for (int t = 0; t < TAPS; t++) begin
                if (msk[b][t]) begin
                    if (!f) begin f = 1; l = t; r = t; end
                    else if (!c) r = t;
                end else if (f) c = 1;
            end
            ef[b] = !f;
            el[b] = f ? l : 0;
            er[b] = f ? r : 0;
            ed[b] = f ? (l + r) / 2 : 0;
            em[b] = f && ((r - l + 1) < minw);
        end
    endtask

    task automatic run_case(input int minw, input int mode);
        int n;
        bit any_fail;
        expect_from_masks(minw);
        rdy_mode = mode;
        min_win  = (TW+1)'(minw);
        wcnt = 0;
        rcnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R10 busy after start", int'(busy), 1);
        n = 0;
        while (!done && n < 40000) begin @(negedge clk); n++; end
        chk(done && !busy && !req_valid, "R10 done state", int'(done), 1);
        chk(wcnt == N * TAPS * BL, "R4 write count", wcnt, N * TAPS * BL);
        chk(rcnt == N * TAPS * BL, "R2 read count", rcnt, N * TAPS * BL);
        any_fail = 0;
        for (int b = 0; b < N; b++) begin
            chk(int'(edge_left[b*TW +: TW]) == el[b], "R6 left edge", int'(edge_left[b*TW +: TW]), el[b]);
            chk(int'(edge_right[b*TW +: TW]) == er[b], "R6 right edge", int'(edge_right[b*TW +: TW]), er[b]);
            chk(int'(dq_delay[b*TW +: TW]) == ed[b], "R7 centre delay", int'(dq_delay[b*TW +: TW]), ed[b]);
            chk(bit_fail[b] == ef[b], "R8 lane fail", int'(bit_fail[b]), int'(ef[b]));
            chk(bit_marginal[b] == em[b], "R9 marginal", int'(bit_marginal[b]), int'(em[b]));
            any_fail |= ef[b];
        end
        chk(err == any_fail, "R8 err", int'(err), int'(any_fail));
        // R5: corruption sits on the last beat only, so these edges also cover it
        repeat (3) @(negedge clk);
        chk(!req_valid && done, "R10 quiet after done", int'(req_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL R10 watchdog: got 0 expected 1");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        min_win = '0;
        for (int b = 0; b < N; b++) msk[b] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !req_valid, "R1 in reset", int'(busy), 0);
        chk(dq_delay == '0 && edge_left == '0 && edge_right == '0
            && bit_fail == '0 && bit_marginal == '0, "R1 outputs in reset", int'(dq_delay), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !req_valid && dq_delay == '0, "R1 after reset", int'(busy), 0);

        // Case 1: ordinary, full, edge-of-range and single-tap windows; stalls
        msk[0] = 16'h03F8; msk[1] = 16'hFFFF; msk[2] = 16'hF000; msk[3] = 16'h0080;
        run_case(4, 1);
        // Case 2: two runs on lane 0, empty lane 1, tap 0 only on lane 2; R5 R6 R8
        msk[0] = 16'h3F1C; msk[1] = 16'h0000; msk[2] = 16'h0001; msk[3] = 16'h7FE0;
        run_case(2, 1);
        // Case 3: all lanes fully open, every window below the minimum; no stalls
        for (int b = 0; b < N; b++) msk[b] = 16'hFFFF;
        run_case(17, 0);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule